// File: doc/BRIEF.md
# MDIO Management Controller

This block is a PHY management engine that software drives through a small set of memory-mapped registers. Each access that starts a transaction becomes one 64-bit clause 22 management frame on MDC/MDIO. The PHY and register numbers are taken from an address register. A write frame starts when the write-data register is written. A read frame starts when the read bit of the command register is set. While a frame is on the wire a busy bit is high. When a read finishes, the 16 bits returned by the PHY appear in a read-data register.

MDC is not free-running. It toggles only while a frame is in progress. Its rate is the system clock divided by one of seven even divisors, chosen by a 3-bit configuration field that comes out of reset at the slowest setting. Software programs the address first and then starts the access. It polls the busy bit, and after a read it collects the data and clears the command register itself.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the status register (offset 4) reads 0, the configuration register (offset 5) reads 6, MDC is low and the MDIO output enable is low.
- R2: The address register (offset 0) keeps the PHY number in bits 12:8 and the register number in bits 4:0, and reads back 0 in every other bit.
- R3: Writing the write-data register (offset 2) while idle sends, MSB first, 32 ones, 01, opcode 01, the 5-bit PHY number, the 5-bit register number, 10 and the 16 data bits. All 64 bits are driven with the output enable high.
- R4: Setting bit 0 of the command register (offset 1) while idle sends 32 ones, 01, opcode 10, the PHY number and the register number. The output enable is then low for the remaining 18 bit times: two turnaround bits and 16 data bits.
- R5: During a read, MDIO is sampled on the rising MDC edge of each of the 16 data bit times, MSB first. Once busy drops, the 16 bits read back at the read-data register (offset 3).
- R6: Status bit 0 (busy) is high from the cycle after the starting access until the falling MDC edge that ends the 64th bit. MDC rises exactly 64 times per frame, and MDC and the output enable stay low whenever busy is low.
- R7: Configuration bits 2:0 select the MDC divisor: codes 0 to 6 give 4, 6, 8, 10, 14, 20 and 28, and code 7 gives 28. MDC is high and low for half the divisor each. The setting in force when a frame starts is used for the whole frame.
- R8: The divisor code after reset is 6 (divide by 28).
- R9: Within a frame, MDIO changes only one system clock after a falling MDC edge.
- R10: Writes to the command or write-data register while busy are ignored. Both registers keep their values and the frame in progress is unchanged.
- R11: The command register keeps its value after a read until software writes it. Writing 0 to it starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset for writes and reads |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Registered read data for the offset of the previous cycle |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable, high when the controller drives |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The hardest state to reach from the ports is a register write that lands in the middle of a frame. It has to arrive while busy is high and after the divisor and frame contents have been captured. The bench reaches it with a directed case. It starts a slow write frame and then, during the preamble, writes new write data, sets the read bit and selects the fastest divisor. It then checks the wire bits, the MDC half-periods and the register readback against the original transaction. Random transactions with a fixed seed cover every divisor code and a range of address and data values for both opcodes. A bench PHY model drives read data on falling MDC edges.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_AW      = 3;
  localparam int DATA_W      = 16;
  localparam int FIELD_W     = 5;
  localparam int SEL_W       = 3;
  localparam int HALF_W      = 4;
  localparam int PRE_BITS    = 32;
  localparam int FRAME_BITS  = PRE_BITS + 4 + 2 * FIELD_W + 2 + DATA_W;
  localparam int IDX_W       = $clog2(FRAME_BITS);
  localparam int TA_FIRST    = FRAME_BITS - DATA_W - 2;
  localparam int DATA_FIRST  = FRAME_BITS - DATA_W;

  localparam logic [REG_AW-1:0] OFS_ADDR  = 3'd0;
  localparam logic [REG_AW-1:0] OFS_CMD   = 3'd1;
  localparam logic [REG_AW-1:0] OFS_WDATA = 3'd2;
  localparam logic [REG_AW-1:0] OFS_RDATA = 3'd3;
  localparam logic [REG_AW-1:0] OFS_STAT  = 3'd4;
  localparam logic [REG_AW-1:0] OFS_CFG   = 3'd5;

  localparam logic [SEL_W-1:0] SEL_RESET = 3'd6;

  // half of the MDC divisor, in system clocks
  function automatic logic [HALF_W-1:0] half_of(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    half_of = 4'd2;
      3'd1:    half_of = 4'd3;
      3'd2:    half_of = 4'd4;
      3'd3:    half_of = 4'd5;
      3'd4:    half_of = 4'd7;
      3'd5:    half_of = 4'd10;
      default: half_of = 4'd14;
    endcase
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              mdc,
  output logic              rise_p,
  output logic              fall_p
);
  logic [HALF_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt    <= '0;
      mdc    <= 1'b0;
      rise_p <= 1'b0;
      fall_p <= 1'b0;
    end else if (cnt == half - 4'd1) begin
      cnt    <= '0;
      mdc    <= ~mdc;
      rise_p <= ~mdc;
      fall_p <= mdc;
    end else begin
      cnt    <= cnt + 4'd1;
      rise_p <= 1'b0;
      fall_p <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start_wr,
  input  logic               start_rd,
  input  logic [FIELD_W-1:0] phy,
  input  logic [FIELD_W-1:0] regn,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [HALF_W-1:0]  half_in,
  input  logic               rise_p,
  input  logic               fall_p,
  input  logic               mdio_i,
  output logic               busy,
  output logic               is_rd,
  output logic [HALF_W-1:0]  half_q,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic [DATA_W-1:0]  rdata
);
  logic [FRAME_BITS-1:0] sh;
  logic [FRAME_BITS-1:0] frm;
  logic [IDX_W-1:0]      idx;
  logic [DATA_W-1:0]     rd_sh;
  logic [IDX_W:0]        idx_nx;
  logic                  oe_nx;

  always_comb begin
    frm = {{PRE_BITS{1'b1}}, 2'b01,
           (start_rd ? 2'b10 : 2'b01), phy, regn,
           (start_rd ? 2'b11 : 2'b10),
           (start_rd ? {DATA_W{1'b0}} : wdata)};
    idx_nx = {1'b0, idx} + 1'b1;
    oe_nx  = !(is_rd && (idx_nx >= (IDX_W+1)'(TA_FIRST)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      is_rd   <= 1'b0;
      half_q  <= half_of(SEL_RESET);
      idx     <= '0;
      sh      <= '0;
      rd_sh   <= '0;
      rdata   <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else if (!busy) begin
      if (start_wr || start_rd) begin
        busy    <= 1'b1;
        is_rd   <= start_rd;
        half_q  <= half_in;
        idx     <= '0;
        sh      <= frm;
        mdio_o  <= frm[FRAME_BITS-1];
        mdio_oe <= 1'b1;
      end
    end else begin
      if (rise_p && is_rd && (idx >= IDX_W'(DATA_FIRST)))
        rd_sh <= {rd_sh[DATA_W-2:0], mdio_i};
      if (fall_p) begin
        if (idx == IDX_W'(FRAME_BITS - 1)) begin
          busy    <= 1'b0;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
          if (is_rd) rdata <= rd_sh;
        end else begin
          idx     <= idx_nx[IDX_W-1:0];
          sh      <= {sh[FRAME_BITS-2:0], 1'b0};
          mdio_o  <= oe_nx ? sh[FRAME_BITS-2] : 1'b1;
          mdio_oe <= oe_nx;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic [FIELD_W-1:0] phy_q, reg_q;
  logic               cmd_q;
  logic [DATA_W-1:0]  wdat_q;
  logic [SEL_W-1:0]   cfg_q;
  logic               busy, eng_is_rd, rise_p, fall_p;
  logic [HALF_W-1:0]  eng_half;
  logic [DATA_W-1:0]  rdata;
  logic               start_wr, start_rd;

  assign start_wr = bus_wr && (bus_addr == OFS_WDATA) && !busy;
  assign start_rd = bus_wr && (bus_addr == OFS_CMD) && bus_wdata[0] && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      phy_q  <= '0;
      reg_q  <= '0;
      cmd_q  <= 1'b0;
      wdat_q <= '0;
      cfg_q  <= SEL_RESET;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_ADDR: begin
          phy_q <= bus_wdata[12:8];
          reg_q <= bus_wdata[4:0];
        end
        OFS_CMD:   if (!busy) cmd_q  <= bus_wdata[0];
        OFS_WDATA: if (!busy) wdat_q <= bus_wdata;
        OFS_CFG:   cfg_q <= bus_wdata[SEL_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        OFS_ADDR:  bus_rdata <= {3'b000, phy_q, 3'b000, reg_q};
        OFS_CMD:   bus_rdata <= {{(DATA_W-1){1'b0}}, cmd_q};
        OFS_WDATA: bus_rdata <= wdat_q;
        OFS_RDATA: bus_rdata <= rdata;
        OFS_STAT:  bus_rdata <= {{(DATA_W-1){1'b0}}, busy};
        OFS_CFG:   bus_rdata <= {{(DATA_W-SEL_W){1'b0}}, cfg_q};
        default:   bus_rdata <= '0;
      endcase
    end
  end

  mdio_clkgen u_clk (
    .clk(clk), .rst(rst), .run(busy), .half(eng_half),
    .mdc(mdc), .rise_p(rise_p), .fall_p(fall_p)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst(rst), .start_wr(start_wr), .start_rd(start_rd),
    .phy(phy_q), .regn(reg_q), .wdata(bus_wdata),
    .half_in(half_of(cfg_q)), .rise_p(rise_p), .fall_p(fall_p),
    .mdio_i(mdio_i), .busy(busy), .is_rd(eng_is_rd), .half_q(eng_half),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rdata(rdata)
  );
endmodule

module mdio_mgmt_ctrl_chk
  import mdio_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic              fall_p,
  input logic              is_rd,
  input logic [HALF_W-1:0] half_q
);
  a_r6_mdc_idle_low: assert property (@(posedge clk) disable iff (rst)
    mdc |-> busy);
  a_r6_oe_idle_low: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> busy);
  a_r6_start_mdc_low: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !mdc);
  a_r9_change_after_fall: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $past(fall_p));
  a_r4_release_only_read: assert property (@(posedge clk) disable iff (rst)
    ($fell(mdio_oe) && busy) |-> is_rd);
  a_r10_frame_kept: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(is_rd) && $stable(half_q)));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .fall_p(fall_p), .is_rd(eng_is_rd), .half_q(eng_half)
);

// File: tb/mdio_mgmt_ctrl_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  mdio_mgmt_ctrl u_mdio_mgmt_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY-side monitor
  logic [63:0] bits, oeb;
  int          rise_cnt;
  logic [15:0] phy_val;
  bit          in_frame = 0, per_bad, chg_bad;
  longint      t_rise, t_fall, exp_half_ns;

  always @(posedge mdc) if (in_frame) begin
    bits = {bits[62:0], mdio_o};
    oeb  = {oeb[62:0], mdio_oe};
    if (rise_cnt > 0 && ($time - t_fall) != exp_half_ns) per_bad = 1;
    rise_cnt++;
    t_rise = $time;
  end

  always @(negedge mdc) if (in_frame) begin
    if (($time - t_rise) != exp_half_ns) per_bad = 1;
    t_fall = $time;
    if (rise_cnt >= 48 && rise_cnt < 64) mdio_i = phy_val[63 - rise_cnt];
    else mdio_i = ~phy_val[15];
  end

  always @(mdio_o) if (in_frame && ($time - t_fall) != 8) chg_bad = 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic int half_exp(input logic [2:0] code);
    case (code)
      3'd0: return 2;  3'd1: return 3;  3'd2: return 4;  3'd3: return 5;
      3'd4: return 7;  3'd5: return 10; default: return 14;
    endcase
  endfunction

  function automatic logic [63:0] frame_exp(input bit rd, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r,
            (rd ? 2'b11 : 2'b10), (rd ? 16'h0 : d)};
  endfunction

  bit          cur_rd;
  logic [4:0]  cur_p, cur_r;
  logic [15:0] cur_d;

  task automatic start_txn(input bit rd, input logic [4:0] p, input logic [4:0] r,
                           input logic [15:0] d, input logic [2:0] code);
    logic [15:0] s;
    bus_write(3'd5, {13'd0, code});
    bus_write(3'd0, {3'd0, p, 3'd0, r});
    cur_rd = rd; cur_p = p; cur_r = r; cur_d = d;
    bits = '0; oeb = '0; rise_cnt = 0; per_bad = 0; chg_bad = 0;
    exp_half_ns = 8 * half_exp(code);
    phy_val = d; t_fall = 0; t_rise = 0;
    in_frame = 1;
    if (rd) bus_write(3'd1, 16'h0001);
    else    bus_write(3'd2, d);
    bus_read(3'd4, s);
    chk(s[0] == 1'b1, "R6 busy after start", s, 1);
  endtask

  task automatic finish_txn();
    logic [15:0] s;
    logic [63:0] ef;
    int n = 0;
    s = 16'd1;
    while (s[0] && n < 5000) begin bus_read(3'd4, s); n++; end
    in_frame = 0;
    chk(s[0] == 1'b0, "R6 busy drops", s, 0);
    chk(rise_cnt == 64, "R6 MDC rising edges per frame", rise_cnt, 64);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R6 idle MDC/OE low", {mdc, mdio_oe}, 0);
    ef = frame_exp(cur_rd, cur_p, cur_r, cur_d);
    if (cur_rd) begin
      chk(bits[63:18] == ef[63:18], "R4 read frame header", bits, ef);
      chk(oeb == {{46{1'b1}}, 18'h0}, "R4 output enable pattern", oeb, {{46{1'b1}}, 18'h0});
      bus_read(3'd3, s);
      chk(s == cur_d, "R5 read data", s, cur_d);
    end else begin
      chk(bits == ef, "R3 write frame", bits, ef);
      chk(oeb == '1, "R3 output enable", oeb, '1);
    end
    chk(!per_bad, "R7 MDC half period", per_bad, 0);
    chk(!chg_bad, "R9 MDIO change timing", chg_bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] s;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 / R8
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 reset pins", {mdc, mdio_oe}, 0);
    bus_read(3'd4, s); chk(s == 16'd0, "R1 status after reset", s, 0);
    bus_read(3'd5, s); chk(s == 16'd6, "R8 divider code after reset", s, 6);

    // R2
    bus_write(3'd0, 16'hFFFF); bus_read(3'd0, s);
    chk(s == 16'h1F1F, "R2 address fields", s, 16'h1F1F);
    bus_write(3'd0, 16'hE0E0); bus_read(3'd0, s);
    chk(s == 16'h0000, "R2 unused address bits", s, 0);

    // directed corners, all divider codes (R7)
    start_txn(0, 5'd31, 5'd31, 16'hFFFF, 3'd0); finish_txn();
    start_txn(1, 5'd0, 5'd0, 16'h0000, 3'd7);   finish_txn();
    start_txn(1, 5'd21, 5'd10, 16'hA5C3, 3'd1); finish_txn();
    start_txn(0, 5'd1, 5'd16, 16'h8001, 3'd2);  finish_txn();
    start_txn(1, 5'd30, 5'd1, 16'h7FFE, 3'd3);  finish_txn();
    start_txn(0, 5'd5, 5'd9, 16'h0F0F, 3'd4);   finish_txn();
    start_txn(1, 5'd17, 5'd2, 16'h1234, 3'd5);  finish_txn();

    // R11: command keeps value, clearing starts nothing
    bus_read(3'd1, s); chk(s == 16'd1, "R11 command kept after read", s, 1);
    bus_write(3'd1, 16'h0000); bus_read(3'd4, s);
    chk(s == 16'd0, "R11 clear starts nothing", s, 0);
    bus_read(3'd1, s); chk(s == 16'd0, "R11 command cleared", s, 0);

    // R10: accesses while busy, divider change mid-frame (R7 latch)
    start_txn(0, 5'd12, 5'd7, 16'hC0DE, 3'd6);
    bus_write(3'd2, 16'h1111);
    bus_write(3'd1, 16'h0001);
    bus_write(3'd5, 16'h0000);
    bus_read(3'd2, s); chk(s == 16'hC0DE, "R10 write data kept", s, 16'hC0DE);
    bus_read(3'd1, s); chk(s == 16'd0, "R10 command kept", s, 0);
    finish_txn();

    // random mix
    for (int i = 0; i < 20; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      start_txn(rv[0], rv[5:1], rv[10:6], rv[26:11], rv[29:27]);
      finish_txn();
      if (rv[0]) bus_write(3'd1, 16'h0000);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule